// File: doc/BRIEF.md
# Driver Startup and Fault Sequencer

This block is the supervisory state machine of an LED driver controller. It watches a set of digital condition flags: supply above the undervoltage threshold, supply at the overvoltage clamp, startup clamp node in regulation, dimmer sense above its high threshold, primary overcurrent, die temperature above the high trip, and die temperature below the release point. From these flags it decides when the power switch may run. It also decides when the startup clamp node is drained, when the dimming set-point filter is held at minimum light, and when the dimmer-detect output is forced high.

All flags come from analog comparators and arrive without a clock relationship, so each passes through a two-flop synchronizer before the state machine acts on it. Each fault has its own way back to normal operation:
- After an overcurrent, switching resumes at minimum light on the next low-to-high crossing of the sense input.
- An overvoltage drains the clamp node until the supply falls under the undervoltage threshold, then restarts from charging.
- An over-temperature does the same, and in addition waits for the low release threshold before the restart.

The current state is brought out as a 3-bit code for test.

Top module: `drv_start_seq`

## Requirements
- R1: While reset is asserted and after it is released with no flag set, the state code is 0 (charging), switching enable and clamp drain are 0, and filter reset and dimmer-detect force are 1.
- R2: Every flag input is resynchronized by two flops. A change applied between clock edges is first acted on at the third rising edge that follows it, and not at an earlier edge.
- R3: The state codes are 0 charging, 1 standby, 2 run, 3 overcurrent wait, 4 overvoltage drain, 5 over-temperature drain and 6 over-temperature hold. From charging the block moves to standby when both the undervoltage-ok flag and the clamp-regulated flag are 1.
- R4: From standby the block moves to run when the sense-high flag is 1. Switching enable is 1 in run and in no other state.
- R5: When the undervoltage-ok flag is 0 in standby, run or overcurrent wait, the block returns to charging.
- R6: An overcurrent in run moves the block to overcurrent wait, which drops switching and asserts filter reset. It leaves for run only on a 0-to-1 transition of the synchronized sense flag. A sense flag held at 1 throughout does not release it.
- R7: An overvoltage in charging, standby, run or overcurrent wait moves the block to overvoltage drain. In that state clamp drain and dimmer-detect force are 1 and switching is 0. The block stays there until the undervoltage-ok flag is 0, then goes to charging.
- R8: A high-temperature flag in any state other than the two over-temperature states moves the block to over-temperature drain, with clamp drain at 1. When the undervoltage-ok flag then reads 0, the block moves to over-temperature hold.
- R9: Over-temperature hold keeps clamp drain at 1 and is left for charging only when the temperature-released flag is 1. The high-temperature flag has no effect there.
- R10: When several conditions are present at once, over-temperature is acted on first, then overvoltage, then loss of undervoltage-ok, and overcurrent last.
- R11: Filter reset is 0 in standby and run and 1 in every other state. Dimmer-detect force is 1 only in charging and overvoltage drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvOkIn | input | 1 | Supply above undervoltage threshold |
| ovpIn | input | 1 | Supply at overvoltage clamp |
| clampRegIn | input | 1 | Startup clamp node in regulation |
| senHighIn | input | 1 | Dimmer sense above high threshold |
| ocIn | input | 1 | Primary overcurrent comparator |
| tempHotIn | input | 1 | Die temperature above high trip |
| tempCoolIn | input | 1 | Die temperature below release point |
| swEn | output | 1 | Power switch enable |
| clampDis | output | 1 | Clamp node discharge enable |
| filtRst | output | 1 | Hold dimming filter at minimum light |
| tddHigh | output | 1 | Force dimmer-detect output high |
| stateCode | output | 3 | Current state code (see R3) |

## Verification
A behavioural reference model with its own input delay line is compared with every output on every clock, while directed sequences walk each recovery path.

The sequences cover the following cases:
- A normal power-up, which separates correct standby gating from a premature start.
- A single flag edge timed against the clock, which pins down the two-flop latency.
- An overcurrent with the sense input held high and then toggled, which distinguishes edge release from level release.
- Overvoltage and over-temperature episodes with the supply flag dropped late, which show that draining persists until undervoltage.
- Several faults raised in the same cycle, which expose the priority order.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_CHARGE    = 3'd0,
    ST_STANDBY   = 3'd1,
    ST_RUN       = 3'd2,
    ST_OC_WAIT   = 3'd3,
    ST_OV_DRAIN  = 3'd4,
    ST_HOT_DRAIN = 3'd5,
    ST_HOT_HOLD  = 3'd6
  } seqState_t;

  typedef struct packed {
    logic tempCool;
    logic tempHot;
    logic ocHit;
    logic senHigh;
    logic clampReg;
    logic ovpHit;
    logic uvOk;
  } seqFlags_t;

  localparam int FLAG_W = $bits(seqFlags_t);

  typedef struct packed {
    logic swEn;
    logic clampDis;
    logic filtRst;
    logic tddHigh;
  } seqStrobe_t;

  localparam seqStrobe_t STROBE_RESET = '{swEn: 1'b0, clampDis: 1'b0,
                                         filtRst: 1'b1, tddHigh: 1'b1};

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqFlags_t  rawFlags,
  input  seqStrobe_t strobeNext,
  output seqFlags_t  syncFlags,
  output logic       senRise,
  output seqStrobe_t strobeQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [FLAG_W-1:0] chain [SYNC_STAGES];
  logic              senPrev;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= '0;
          else       chain[g] <= rawFlags;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= '0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncFlags = seqFlags_t'(chain[LAST]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) senPrev <= 1'b0;
    else       senPrev <= syncFlags.senHigh;
  end

  assign senRise = syncFlags.senHigh & ~senPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= STROBE_RESET;
    else       strobeQ <= strobeNext;
  end

  AST_DRAIN_NO_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ.clampDis |-> !strobeQ.swEn);  // R7

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqFlags_t  sf,
  input  logic       senRise,
  output seqState_t  stateQ,
  output seqStrobe_t strobeNext
);

  seqState_t nxt;
  logic      inHot;
  logic      normalState;

  assign inHot       = (stateQ == ST_HOT_DRAIN) || (stateQ == ST_HOT_HOLD);
  assign normalState = (stateQ == ST_CHARGE) || (stateQ == ST_STANDBY) ||
                       (stateQ == ST_RUN)    || (stateQ == ST_OC_WAIT);

  always_comb begin
    nxt = stateQ;
    if (stateQ == ST_HOT_HOLD) begin
      if (sf.tempCool) nxt = ST_CHARGE;
    end else if (stateQ == ST_HOT_DRAIN) begin
      if (!sf.uvOk) nxt = ST_HOT_HOLD;
    end else if (sf.tempHot) begin
      nxt = ST_HOT_DRAIN;
    end else if (stateQ == ST_OV_DRAIN) begin
      if (!sf.uvOk) nxt = ST_CHARGE;
    end else if (sf.ovpHit) begin
      nxt = ST_OV_DRAIN;
    end else if (!sf.uvOk) begin
      nxt = ST_CHARGE;
    end else begin
      case (stateQ)
        ST_CHARGE:  if (sf.clampReg) nxt = ST_STANDBY;
        ST_STANDBY: if (sf.senHigh)  nxt = ST_RUN;
        ST_RUN:     if (sf.ocHit)    nxt = ST_OC_WAIT;
        ST_OC_WAIT: if (senRise)     nxt = ST_RUN;
        default:                     nxt = ST_CHARGE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_CHARGE;
    else       stateQ <= nxt;
  end

  always_comb begin
    strobeNext.swEn     = (nxt == ST_RUN);
    strobeNext.clampDis = (nxt == ST_OV_DRAIN) || (nxt == ST_HOT_DRAIN) ||
                          (nxt == ST_HOT_HOLD);
    strobeNext.filtRst  = !((nxt == ST_STANDBY) || (nxt == ST_RUN));
    strobeNext.tddHigh  = (nxt == ST_CHARGE) || (nxt == ST_OV_DRAIN);
  end

  AST_HOT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (sf.tempHot && !inHot) |=> (stateQ == ST_HOT_DRAIN));  // R8

  AST_OVP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (sf.ovpHit && !sf.tempHot && normalState) |=> (stateQ == ST_OV_DRAIN));  // R7

  AST_OC_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && sf.ocHit && !sf.tempHot && !sf.ovpHit && sf.uvOk)
      |=> (stateQ == ST_OC_WAIT));  // R6

  AST_OC_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OC_WAIT && !senRise && !sf.tempHot && !sf.ovpHit && sf.uvOk)
      |=> (stateQ == ST_OC_WAIT));  // R6

  AST_HOLD_UNTIL_COOL: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOT_HOLD && !sf.tempCool) |=> (stateQ == ST_HOT_HOLD));  // R9

  AST_UV_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!sf.uvOk && !sf.tempHot && !sf.ovpHit &&
     (stateQ == ST_STANDBY || stateQ == ST_RUN || stateQ == ST_OC_WAIT))
      |=> (stateQ == ST_CHARGE));  // R5

endmodule

// File: rtl/drv_start_seq.sv
module drv_start_seq
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvOkIn,
  input  logic       ovpIn,
  input  logic       clampRegIn,
  input  logic       senHighIn,
  input  logic       ocIn,
  input  logic       tempHotIn,
  input  logic       tempCoolIn,
  output logic       swEn,
  output logic       clampDis,
  output logic       filtRst,
  output logic       tddHigh,
  output logic [2:0] stateCode
);

  seqFlags_t  rawFlags;
  seqFlags_t  syncFlags;
  seqStrobe_t strobeNext;
  seqStrobe_t strobeQ;
  seqState_t  stateQ;
  logic       senRise;

  always_comb begin
    rawFlags.uvOk     = uvOkIn;
    rawFlags.ovpHit   = ovpIn;
    rawFlags.clampReg = clampRegIn;
    rawFlags.senHigh  = senHighIn;
    rawFlags.ocHit    = ocIn;
    rawFlags.tempHot  = tempHotIn;
    rawFlags.tempCool = tempCoolIn;
  end

  seq_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .rawFlags   (rawFlags),
    .strobeNext (strobeNext),
    .syncFlags  (syncFlags),
    .senRise    (senRise),
    .strobeQ    (strobeQ)
  );

  seq_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .sf         (syncFlags),
    .senRise    (senRise),
    .stateQ     (stateQ),
    .strobeNext (strobeNext)
  );

  assign swEn      = strobeQ.swEn;
  assign clampDis  = strobeQ.clampDis;
  assign filtRst   = strobeQ.filtRst;
  assign tddHigh   = strobeQ.tddHigh;
  assign stateCode = stateQ;

  AST_SWITCH_ONLY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    swEn |-> (stateCode == ST_RUN));  // R4

  AST_OVP_FORCES_TDD: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_OV_DRAIN) |-> (tddHigh && clampDis));  // R7

  AST_RUN_FILTER_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_RUN) |-> !filtRst);  // R11

endmodule

// File: tb/drv_start_seq_test.sv
`timescale 1ns/1ps
module drv_start_seq_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uv = 0, ovp = 0, creg = 0, sen = 0, oc = 0, hot = 0, cool = 0;
  logic swEn, clampDis, filtRst, tddHigh;
  logic [2:0] stateCode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  drv_start_seq uut (
    .clk(clk), .rstN(rstN), .uvOkIn(uv), .ovpIn(ovp), .clampRegIn(creg),
    .senHighIn(sen), .ocIn(oc), .tempHotIn(hot), .tempCoolIn(cool),
    .swEn(swEn), .clampDis(clampDis), .filtRst(filtRst), .tddHigh(tddHigh),
    .stateCode(stateCode)
  );

  // Reference model: input delay queue plus a behavioural state decision.
  logic [6:0] inNow;
  logic [6:0] dly [$];
  int refSt = 0;
  bit refPrevSen = 0;
  assign inNow = {cool, hot, oc, sen, creg, ovp, uv};

  function automatic int decide(int s, logic [6:0] f, bit risen);
    bit fUv = f[0], fOv = f[1], fCr = f[2], fSen = f[3], fOc = f[4];
    bit fHot = f[5], fCool = f[6];
    if (s == 6) return fCool ? 0 : 6;
    if (s == 5) return fUv ? 5 : 6;
    if (fHot) return 5;
    if (s == 4) return fUv ? 4 : 0;
    if (fOv) return 4;
    if (!fUv) return 0;
    if (s == 0) return fCr ? 1 : 0;
    if (s == 1) return fSen ? 2 : 1;
    if (s == 2) return fOc ? 3 : 2;
    return risen ? 2 : 3;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dly = {7'd0, 7'd0};
      refSt = 0;
      refPrevSen = 0;
    end else begin
      logic [6:0] seen;
      seen = dly[1];
      refSt = decide(refSt, seen, seen[3] && !refPrevSen);
      refPrevSen = seen[3];
      void'(dly.pop_back());
      dly.push_front(inNow);
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      cmp("state", stateCode, refSt);
      cmp("swEn", swEn, refSt == 2);
      cmp("clampDis", clampDis, refSt >= 4);
      cmp("filtRst", filtRst, !(refSt == 1 || refSt == 2));
      cmp("tddHigh", tddHigh, refSt == 0 || refSt == 4);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    tag = "R1";
    cmp("reset state", stateCode, 0);
    cmp("reset filtRst", filtRst, 1);
    cmp("reset tddHigh", tddHigh, 1);
    cmp("reset swEn", swEn, 0);
    rstN = 1'b1;
    wait_n(4);
    cmp("idle state R1", stateCode, 0);

    tag = "R3";
    uv = 1; creg = 1;
    wait_n(5);
    cmp("standby code", stateCode, 1);
    tag = "R11";
    cmp("standby filtRst", filtRst, 0);

    tag = "R2";
    sen = 1;
    wait_n(1); cmp("edge1", stateCode, 1);
    wait_n(1); cmp("edge2", stateCode, 1);
    wait_n(1); cmp("edge3", stateCode, 2);
    tag = "R4";
    cmp("run swEn", swEn, 1);

    tag = "R6";
    oc = 1; wait_n(1); oc = 0;
    wait_n(4);
    cmp("oc wait", stateCode, 3);
    cmp("oc swEn", swEn, 0);
    cmp("oc filtRst", filtRst, 1);
    wait_n(8);
    cmp("held sense no release", stateCode, 3);
    sen = 0; wait_n(4);
    sen = 1; wait_n(5);
    cmp("release on rise", stateCode, 2);

    tag = "R5";
    uv = 0; wait_n(5);
    cmp("uv loss", stateCode, 0);
    uv = 1; wait_n(8);
    cmp("back to run", stateCode, 2);

    tag = "R7";
    ovp = 1; wait_n(5);
    cmp("ovp drain", stateCode, 4);
    cmp("ovp tdd", tddHigh, 1);
    cmp("ovp clampDis", clampDis, 1);
    ovp = 0; wait_n(6);
    cmp("ovp stays until uv", stateCode, 4);
    uv = 0; wait_n(5);
    cmp("ovp restart", stateCode, 0);
    uv = 1; wait_n(8);
    cmp("run again", stateCode, 2);

    tag = "R8";
    hot = 1; wait_n(5);
    cmp("hot drain", stateCode, 5);
    cmp("hot clampDis", clampDis, 1);
    uv = 0; wait_n(5);
    cmp("hot hold", stateCode, 6);
    tag = "R9";
    hot = 0; wait_n(6);
    cmp("hold without release", stateCode, 6);
    cmp("hold clampDis", clampDis, 1);
    hot = 1; wait_n(4);
    cmp("hot ignored in hold", stateCode, 6);
    hot = 0; cool = 1; wait_n(5);
    cmp("hold exit", stateCode, 0);
    cool = 0; uv = 1; wait_n(8);
    cmp("run after cool", stateCode, 2);

    tag = "R10";
    hot = 1; ovp = 1; oc = 1; wait_n(5);
    cmp("hot beats all", stateCode, 5);
    hot = 0; ovp = 0; oc = 0; uv = 0; wait_n(4);
    cool = 1; wait_n(4); cool = 0; uv = 1; wait_n(8);
    cmp("run before ovp+oc", stateCode, 2);
    ovp = 1; oc = 1; wait_n(5);
    cmp("ovp beats oc", stateCode, 4);
    ovp = 0; oc = 0; uv = 0; wait_n(4);
    uv = 1; wait_n(8);
    uv = 0; oc = 1; wait_n(5);
    cmp("uv beats oc", stateCode, 0);
    oc = 0; wait_n(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule